// File: doc/BRIEF.md
# Clock-Sampled Asynchronous DRAM Device Model

This block is a synthesizable behavioural model of one asynchronous, page-mode DRAM device. It is the target that a DRAM controller drives during verification. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable, together with a multiplexed address bus and a write-data bus. The model finds edges by comparing each sample with the one before it. It keeps a small register array whose index is formed from the low bits of the captured row and column addresses.

The model decides three things: when a write lands in the array, when the data outputs are driven (`dq_oe`), and how long read data is held. Two writes are modelled. In an early write, write enable is LOW before the column strobe falls. In a late write, write enable falls while a read cycle is open, and output enable decides whether that write happens. The parameter `EDO_MODE` selects the read-hold behaviour. At 0 (fast-page), the outputs release when the column strobe rises. At 1 (extended data out), the data is held past that edge. A column strobe that is already LOW when the row strobe falls starts a refresh cycle. That cycle uses an internal wrapping row counter, and `ref_row` reports the row most recently refreshed.

Every pin change takes effect exactly two clock cycles after the clock edge that first samples it: one register samples the pin and one acts on it.

Top module: `dram_async_model`

## Requirements
- R1: After reset, `dq_oe` is 0, `ref_row` is 0 and every array word reads as 0.
- R2: A column-strobe fall with write enable already LOW (early write) stores `dq_in` at index {row[ROW_BITS-1:0], col[COL_BITS-1:0]}. During that write `dq_oe` stays 0, even with output enable LOW.
- R3: A column-strobe fall with write enable HIGH opens a read. `dq_out` then carries the word at the addressed index, and `dq_oe` is 1 exactly while output enable is LOW.
- R4: Write enable falling during an open read, with output enable HIGH, is a late write. It stores the `dq_in` sampled at that fall at the open column and turns the outputs off.
- R5: Write enable falling during an open read, with output enable LOW, writes nothing. The outputs keep driving the old word.
- R6: With EDO_MODE=0, `dq_oe` goes to 0 once the column strobe is HIGH.
- R7: With EDO_MODE=1, read data stays driven after the column strobe rises. This lasts while the row strobe and output enable stay LOW and write enable stays HIGH. Any one of those conditions ending releases the outputs.
- R8: If the column strobe is LOW at the row-strobe fall, the cycle is a refresh. `ref_row` takes the counter value, the counter steps by one and wraps at 2^ROW_BITS, and the address pins and array contents are left untouched.
- R9: Outputs are never driven while the row strobe is HIGH, and no write occurs while it is HIGH.
- R10: Successive column cycles within one row-strobe LOW period use the row captured at that row-strobe fall (page mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active LOW |
| cas_n | input | 1 | Column strobe, active LOW |
| we_n | input | 1 | Write enable, active LOW |
| oe_n | input | 1 | Output enable, active LOW |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, zero when not driven |
| dq_oe | output | 1 | High when the data outputs are driven |
| ref_row | output | ROW_BITS | Row used by the most recent refresh cycle |

## Verification
The bench builds two copies of the model side by side, one with EDO_MODE=0 and one with EDO_MODE=1, and drives both with the same strobes. The two copies behave differently only after the column strobe rises, so that difference is checked under identical stimulus. ROW_BITS=3 and COL_BITS=3 give a 64-word array, which the randomized writes and reads cover densely. Those widths also let ten refresh cycles pass the counter wrap at eight.

// File: rtl/dram_model_pkg.sv
// Shared helpers for the DRAM device model.
// Assumes: row and column index widths are small enough for a register array.
package dram_model_pkg;

    // Build the array index from a row and a column value.
    function automatic logic [15:0] cell_index(input logic [7:0] row, input logic [7:0] col,
                                               input int col_bits);
        return 16'((32'(row) << col_bits) | 32'(col));
    endfunction

endpackage

// File: rtl/dram_pin_sampler.sv
// Samples the strobe pins on the system clock and flags their edges.
// Assumes: strobes are synchronous to clk or slow enough for single-stage capture.
module dram_pin_sampler #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              s_ras,
    output logic              s_cas,
    output logic              s_we,
    output logic              s_oe,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_din,
    output logic              ras_fall,
    output logic              cas_fall,
    output logic              cas_rise,
    output logic              we_fall
);
    logic p_ras, p_cas, p_we;

    // Capture the current pin levels and keep the previous strobe levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {s_ras, s_cas, s_we, s_oe} <= 4'b1111;
            {p_ras, p_cas, p_we}       <= 3'b111;
            s_addr <= '0;
            s_din  <= '0;
        end else begin
            {s_ras, s_cas, s_we, s_oe} <= {ras_n, cas_n, we_n, oe_n};
            {p_ras, p_cas, p_we}       <= {s_ras, s_cas, s_we};
            s_addr <= addr;
            s_din  <= dq_in;
        end
    end

    // Edge flags from the previous and current samples.
    always_comb begin
        ras_fall = p_ras & ~s_ras;
        cas_fall = p_cas & ~s_cas;
        cas_rise = ~p_cas & s_cas;
        we_fall  = p_we & ~s_we;
    end
endmodule

// File: rtl/dram_cell_array.sv
// Register array holding the reduced set of DRAM words; one write, one read port.
// Assumes: 2^IDX_W words fit comfortably in flops.
module dram_cell_array #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read of the open location.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/dram_refresh_counter.sv
// Internal refresh row counter; steps once per refresh cycle and wraps.
// Assumes: step is a single-cycle pulse.
module dram_refresh_counter #(
    parameter int ROW_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [ROW_BITS-1:0] last_row
);
    logic [ROW_BITS-1:0] cnt;

    // Report the row being refreshed and advance the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            last_row <= '0;
        end else if (step) begin
            last_row <= cnt;
            cnt      <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dram_access_ctrl.sv
// Cycle decoder: opens rows, classifies column cycles, issues writes and
// decides the output-drive window for fast-page or extended-data-out reads.
// Assumes: inputs come from dram_pin_sampler.
module dram_access_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    parameter bit EDO_MODE = 1'b0,
    localparam int IDX_W   = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ras,
    input  logic              s_cas,
    input  logic              s_we,
    input  logic              s_oe,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_din,
    input  logic              ras_fall,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              we_fall,
    output logic              wr_en,
    output logic [IDX_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  raddr,
    output logic              ref_step,
    output logic              dq_oe
);
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic active_q, rd_q, hold_q;
    logic active_d, rd_d, hold_d, col_ok, early_wr, late_try, late_wr;

    // Classify the current sample: column cycle, early/late write, refresh.
    always_comb begin
        col_ok   = cas_fall & active_q;
        early_wr = col_ok & ~s_we;
        late_try = rd_q & we_fall & ~s_cas;
        late_wr  = late_try & s_oe;
        wr_en    = early_wr | late_wr;
        waddr    = early_wr ? {row_q, s_addr[COL_BITS-1:0]} : {row_q, col_q};
        wdata    = s_din;
        raddr    = {row_q, col_q};
        ref_step = ras_fall & ~s_cas;
    end

    // Next-state terms for the open row, open read and EDO hold.
    always_comb begin
        if (s_ras)                 active_d = 1'b0;
        else if (ras_fall & s_cas) active_d = 1'b1;
        else                       active_d = active_q;

        if (s_ras)        rd_d = 1'b0;
        else if (col_ok)  rd_d = s_we;
        else if (late_wr) rd_d = 1'b0;
        else if (s_cas)   rd_d = 1'b0;
        else              rd_d = rd_q;

        if (!EDO_MODE || s_ras || s_oe || !s_we) hold_d = 1'b0;
        else if (cas_rise && rd_q)               hold_d = 1'b1;
        else if (col_ok)                         hold_d = 1'b0;
        else                                     hold_d = hold_q;
    end

    // Register the cycle state, captured addresses and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            col_q    <= '0;
            active_q <= 1'b0;
            rd_q     <= 1'b0;
            hold_q   <= 1'b0;
            dq_oe    <= 1'b0;
        end else begin
            if (ras_fall & s_cas) row_q <= s_addr[ROW_BITS-1:0];
            if (col_ok)           col_q <= s_addr[COL_BITS-1:0];
            active_q <= active_d;
            rd_q     <= rd_d;
            hold_q   <= hold_d;
            dq_oe    <= (rd_d | hold_d) & ~s_oe;
        end
    end
endmodule

// File: rtl/dram_async_model.sv
// Top of the clock-sampled asynchronous DRAM model.
// Assumes: clk is fast relative to strobe timing; pin effects appear two cycles
// after first sampling.
module dram_async_model #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    parameter bit EDO_MODE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   dq_in,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe,
    output logic [ROW_BITS-1:0] ref_row
);
    localparam int IDX_W = ROW_BITS + COL_BITS;

    logic s_ras, s_cas, s_we, s_oe, ras_fall, cas_fall, cas_rise, we_fall;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din, wdata, rdata;
    logic [IDX_W-1:0]  waddr, raddr;
    logic              wr_en, ref_step;

    dram_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .s_ras(s_ras), .s_cas(s_cas),
        .s_we(s_we), .s_oe(s_oe), .s_addr(s_addr), .s_din(s_din),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall));

    dram_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS),
                       .COL_BITS(COL_BITS), .EDO_MODE(EDO_MODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we),
        .s_oe(s_oe), .s_addr(s_addr), .s_din(s_din), .ras_fall(ras_fall),
        .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall), .wr_en(wr_en),
        .waddr(waddr), .wdata(wdata), .raddr(raddr), .ref_step(ref_step), .dq_oe(dq_oe));

    dram_cell_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata));

    dram_refresh_counter #(.ROW_BITS(ROW_BITS)) u_refresh (
        .clk(clk), .rst_n(rst_n), .step(ref_step), .last_row(ref_row));

    // Present read data only while the outputs are driven.
    always_comb dq_out = dq_oe ? rdata : '0;
endmodule

// File: rtl/dram_async_model_chk.sv
// Property checker for dram_async_model, attached by bind.
// Assumes: two-cycle pin-to-effect latency of the model.
module dram_async_model_chk #(
    parameter int ROW_BITS = 3,
    parameter bit EDO_MODE = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ras_n,
    input logic                cas_n,
    input logic                oe_n,
    input logic                dq_oe,
    input logic                wr_en,
    input logic [ROW_BITS-1:0] ref_row
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dq_oe && ref_row == '0)); // R1
    AST_OE_GATES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(oe_n, 2)); // R3
    AST_FPM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !EDO_MODE) |-> !$past(cas_n, 2)); // R6
    AST_NO_DRIVE_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(ras_n, 2)); // R9
    AST_NO_WRITE_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(ras_n)); // R9
    AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_row) |-> ref_row == ROW_BITS'($past(ref_row) + 1'b1)); // R8
endmodule

bind dram_async_model dram_async_model_chk #(.ROW_BITS(ROW_BITS), .EDO_MODE(EDO_MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .dq_oe(dq_oe), .wr_en(wr_en), .ref_row(ref_row));

// File: tb/dram_async_model_bench.sv
// Bench: one fast-page and one EDO copy driven with the same strobes.
module dram_async_model_bench;
    localparam int RB = 3, CB = 3, DW = 16, AW = 12;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_f, dq_e;
    logic oe_f, oe_e;
    logic [RB-1:0] rr_f, rr_e;
    logic [DW-1:0] shadow [64];
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dram_async_model #(.ADDR_W(AW), .DATA_W(DW), .ROW_BITS(RB), .COL_BITS(CB), .EDO_MODE(0))
        u_dram_async_model (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_f), .dq_oe(oe_f), .ref_row(rr_f));
    dram_async_model #(.ADDR_W(AW), .DATA_W(DW), .ROW_BITS(RB), .COL_BITS(CB), .EDO_MODE(1))
        u_dram_async_model_edo (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_e), .dq_oe(oe_e), .ref_row(rr_e));

    function automatic int idx(input int r, input int c);
        return ((r % 8) << CB) | (c % 8);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pins set at a falling edge take effect two rising edges later.
    task automatic step();
        repeat (3) @(negedge clk);
    endtask

    task automatic idle();
        ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; step();
    endtask

    task automatic early_write(input int r, input int c, input logic [DW-1:0] d);
        addr = AW'(r); ras_n = 0; oe_n = 0; step();
        we_n = 0; dq_in = d; step();
        addr = AW'(c); cas_n = 0; step();
        chk(!oe_f && !oe_e, "R2 early write outputs off", {oe_f, oe_e}, 0);
        shadow[idx(r, c)] = d;
        idle();
    endtask

    task automatic read_check(input int r, input int c, input string tag);
        addr = AW'(r); ras_n = 0; we_n = 1; oe_n = 0; step();
        addr = AW'(c); cas_n = 0; step();
        chk(oe_f && oe_e, {tag, " drive"}, {oe_f, oe_e}, 3);
        chk(dq_f == shadow[idx(r, c)] && dq_e == dq_f, {tag, " data"}, dq_f, shadow[idx(r, c)]);
        idle();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) shadow[i] = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!oe_f && !oe_e && rr_f == 0 && rr_e == 0, "R1 reset outputs", {oe_f, oe_e, rr_f}, 0);
        read_check(5, 6, "R1 reset array");

        // Directed early write then read.
        early_write(2, 3, 16'hA5C3);
        read_check(2, 3, "R3 read");

        // OE toggling during a read.
        addr = 2; ras_n = 0; oe_n = 1; step();
        addr = 3; cas_n = 0; step();
        chk(!oe_f && !oe_e, "R3 oe high quiet", {oe_f, oe_e}, 0);
        oe_n = 0; step();
        chk(oe_f && dq_f == 16'hA5C3, "R3 oe low drives", dq_f, 16'hA5C3);
        // Column rise: fast-page releases, EDO holds.
        cas_n = 1; step();
        chk(!oe_f, "R6 fpm release", oe_f, 0);
        chk(oe_e && dq_e == 16'hA5C3, "R7 edo hold", dq_e, 16'hA5C3);
        oe_n = 1; step();
        chk(!oe_e, "R7 edo release on oe", oe_e, 0);
        idle();

        // EDO release by WE low and by RAS high.
        addr = 2; ras_n = 0; oe_n = 0; step();
        addr = 3; cas_n = 0; step(); cas_n = 1; step();
        chk(oe_e, "R7 edo hold before we", oe_e, 1);
        we_n = 0; step();
        chk(!oe_e, "R7 edo release on we", oe_e, 0);
        idle();
        addr = 2; ras_n = 0; oe_n = 0; step();
        addr = 3; cas_n = 0; step(); cas_n = 1; step();
        ras_n = 1; step();
        chk(!oe_e && !oe_f, "R9 release on ras high", oe_e, 0);
        idle();

        // Late write with OE high.
        addr = 4; ras_n = 0; oe_n = 1; step();
        addr = 1; cas_n = 0; step();
        dq_in = 16'h1234; we_n = 0; step();
        chk(!oe_f && !oe_e, "R4 late write outputs off", {oe_f, oe_e}, 0);
        shadow[idx(4, 1)] = 16'h1234;
        idle();
        read_check(4, 1, "R4 late write stored");

        // Late write blocked by OE low.
        addr = 4; ras_n = 0; oe_n = 0; step();
        addr = 1; cas_n = 0; step();
        dq_in = 16'hDEAD; we_n = 0; step();
        chk(oe_f && oe_e && dq_f == 16'h1234, "R5 blocked keeps driving", dq_f, 16'h1234);
        idle();
        read_check(4, 1, "R5 blocked no write");

        // Page mode: two columns under one row.
        early_write(6, 0, 16'h0F0F);
        early_write(6, 7, 16'hF00F);
        addr = 6; ras_n = 0; oe_n = 0; step();
        addr = 0; cas_n = 0; step();
        chk(dq_f == 16'h0F0F, "R10 page col a", dq_f, 16'h0F0F);
        cas_n = 1; addr = 7; step(); cas_n = 0; step();
        chk(dq_f == 16'hF00F && dq_e == 16'hF00F, "R10 page col b", dq_f, 16'hF00F);
        idle();

        // Write attempt with RAS high is ignored.
        addr = 2; we_n = 0; dq_in = 16'h7777; cas_n = 0; step();
        chk(!oe_f && !oe_e, "R9 no drive ras high", {oe_f, oe_e}, 0);
        idle();
        read_check(2, 3, "R9 no write ras high");

        // Refresh cycles across the counter wrap.
        for (int k = 0; k < 10; k++) begin
            addr = AW'($urandom_range(0, 7)); dq_in = 16'hBEEF;
            cas_n = 0; step(); ras_n = 0; step();
            chk(rr_f == RB'(k) && rr_e == RB'(k), "R8 refresh row", rr_f, k % 8);
            chk(!oe_f && !oe_e, "R8 refresh quiet", {oe_f, oe_e}, 0);
            idle();
        end
        read_check(2, 3, "R8 array untouched");

        // Random early writes and reads.
        for (int n = 0; n < 40; n++) begin
            early_write($urandom_range(0, 7), $urandom_range(0, 7), DW'($urandom));
        end
        for (int n = 0; n < 40; n++) begin
            read_check($urandom_range(0, 7), $urandom_range(0, 7), "R3 random read");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule